// File: doc/BRIEF.md
# Two-Channel Interleaving Address Mapper

This block sits in front of a two-channel memory controller. It takes a system physical address, works out which physical channel serves it, and produces the address local to that channel. Three configuration inputs describe the memory population: the capacity of logical channel A, the capacity of logical channel B, and a swap bit. The swap bit routes logical A to physical channel 0 or to physical channel 1, and logical B to the other one. Capacities are 8-bit counts of 64 MB units.

The address space has two regions, and both are in use at the same time. The lower region is twice the size of channel B and alternates between the two channels every 64 bytes. The upper region holds the extra capacity of channel A and maps linearly into channel A only. If channel B is empty, every address goes to channel A unchanged. Channel A must never be smaller than channel B. Any other setting is reported as invalid, and no channel is selected.

The mapping is combinational. One register stage sits at the output, so each request gets its answer one clock later. The block does not decode ranks, banks, rows or columns.

Top module: `flexch_addr_map`

## Requirements
- R1: A response appears exactly one clock edge after its request: `rsp_valid` is `req_valid` delayed by one cycle. During synchronous active-low reset all outputs are 0, and an idle cycle (`rsp_valid`=0) never selects a channel.
- R2: If `cfg_size_a` < `cfg_size_b`, `rsp_cfg_bad`=1 and `rsp_hit`=0. Otherwise `rsp_cfg_bad`=0.
- R3: If the address is at or above (`cfg_size_a`+`cfg_size_b`)·2^26, `rsp_oor`=1 and `rsp_hit`=0.
- R4: An in-range address below 2·`cfg_size_b`·2^26 is in the interleaved zone (`rsp_ilv`=1). Address bit 6 picks the logical channel: 0 picks A and 1 picks B.
- R5: In the interleaved zone the local address is the system address with bit 6 removed. Bits 5..0 stay in place and every bit above 6 moves down by one position.
- R6: An in-range address at or above 2·`cfg_size_b`·2^26 goes to logical channel A with `rsp_ilv`=0. Its local address is the system address minus `cfg_size_b`·2^26.
- R7: With `cfg_size_b`=0, every in-range address goes to logical A, and the local address equals the system address.
- R8: The physical channel `rsp_chan` is the logical channel (A=0, B=1) XOR `cfg_swap`.
- R9: When `rsp_hit`=0, the outputs `rsp_chan`, `rsp_local` and `rsp_ilv` are all 0.
- R10: A valid response has `rsp_hit`=1 exactly when neither `rsp_oor` nor `rsp_cfg_bad` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | 35 | System physical address |
| cfg_size_a | input | 8 | Logical channel A capacity, in 64 MB units |
| cfg_size_b | input | 8 | Logical channel B capacity, in 64 MB units |
| cfg_swap | input | 1 | 0: A on physical 0. 1: A on physical 1 |
| rsp_valid | output | 1 | A response is present |
| rsp_hit | output | 1 | A channel is selected |
| rsp_chan | output | 1 | Selected physical channel |
| rsp_local | output | 34 | Address local to the selected channel |
| rsp_ilv | output | 1 | The address fell in the interleaved zone |
| rsp_oor | output | 1 | The address is beyond the total capacity |
| rsp_cfg_bad | output | 1 | The sizes break the rule A ≥ B |

## Verification
An invalid configuration and an out-of-range address can occur in the same response, and each flag must be raised on its own merits. The bench provokes this on purpose: it sets A smaller than B and sends an address above A+B, then one below it. It expects both flags on the first response and only the configuration flag on the second, with no channel selected either time. Random stimulus with occasional inverted sizes also hits this overlap at zone boundaries.

// File: rtl/flexch_pkg.sv
// Package flexch_pkg
// Shared widths and the response record for the two-channel address mapper.
// Assumes 64 MB capacity units (2^26 bytes) and a 64-byte interleave granule.
package flexch_pkg;
    localparam int SIZE_W     = 8;
    localparam int UNIT_SHIFT = 26;
    localparam int ILV_BIT    = 6;
    localparam int ADDR_W     = SIZE_W + 1 + UNIT_SHIFT;
    localparam int LOCAL_W    = SIZE_W + UNIT_SHIFT;

    // logical channel identifiers
    typedef enum logic {
        LCH_A = 1'b0,
        LCH_B = 1'b1
    } lch_e;

    // one registered response
    typedef struct packed {
        logic               valid;
        logic               hit;
        logic               chan;
        logic [LOCAL_W-1:0] local_addr;
        logic               ilv;
        logic               oor;
        logic               cfg_bad;
    } rsp_t;
endpackage

// File: rtl/flexch_zone_cmp.sv
// Module flexch_zone_cmp
// Classifies an address against the configured capacities.
// Assumes every zone boundary is a whole number of capacity units, so only
// the address bits above UNIT_SHIFT are compared.
module flexch_zone_cmp #(
    parameter int SIZE_W     = 8,
    parameter int UNIT_SHIFT = 26,
    localparam int ADDR_W    = SIZE_W + 1 + UNIT_SHIFT
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size_a,
    input  logic [SIZE_W-1:0] size_b,
    output logic              in_range,
    output logic              in_ilv,
    output logic              cfg_bad
);
    localparam int HI_W = SIZE_W + 1;

    logic [HI_W-1:0] addr_hi;
    logic [HI_W-1:0] total_units;
    logic [HI_W-1:0] ilv_units;

    // unit-granular boundaries of the two zones
    always_comb begin
        addr_hi     = addr[ADDR_W-1:UNIT_SHIFT];
        total_units = {1'b0, size_a} + {1'b0, size_b};
        ilv_units   = {size_b, 1'b0};
    end

    // zone and validity decisions
    always_comb begin
        cfg_bad  = (size_a < size_b);
        in_range = (addr_hi < total_units);
        in_ilv   = (addr_hi < ilv_units);
    end
endmodule

// File: rtl/flexch_local_calc.sv
// Module flexch_local_calc
// Builds the channel-local address and the logical channel for one address.
// Assumes the caller has already classified the address: in_ilv says which
// zone applies. The result is meaningful only for in-range addresses.
module flexch_local_calc #(
    parameter int SIZE_W     = 8,
    parameter int UNIT_SHIFT = 26,
    parameter int ILV_BIT    = 6,
    localparam int ADDR_W    = SIZE_W + 1 + UNIT_SHIFT,
    localparam int LOCAL_W   = SIZE_W + UNIT_SHIFT
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [SIZE_W-1:0]  size_b,
    input  logic               in_ilv,
    output logic               lch_b,
    output logic [LOCAL_W-1:0] local_addr
);
    localparam int HI_W = SIZE_W + 1;

    logic [LOCAL_W-1:0] ilv_local;
    logic [LOCAL_W-1:0] lin_local;
    logic [HI_W-1:0]    lin_hi;

    // interleaved zone: remove the granule-select bit
    generate
        if (ILV_BIT == 0) begin : g_squeeze_lsb
            always_comb ilv_local = addr[ADDR_W-1:1];
        end else begin : g_squeeze_mid
            always_comb ilv_local = {addr[ADDR_W-1:ILV_BIT+1], addr[ILV_BIT-1:0]};
        end
    endgenerate

    // linear zone: subtract channel B capacity at unit granularity
    always_comb begin
        lin_hi    = addr[ADDR_W-1:UNIT_SHIFT] - {1'b0, size_b};
        lin_local = {lin_hi[SIZE_W-1:0], addr[UNIT_SHIFT-1:0]};
    end

    // pick logical channel and local address by zone
    always_comb begin
        if (in_ilv) begin
            lch_b      = addr[ILV_BIT];
            local_addr = ilv_local;
        end else begin
            lch_b      = 1'b0;
            local_addr = lin_local;
        end
    end
endmodule

// File: rtl/flexch_chan_map.sv
// Module flexch_chan_map
// Turns a logical channel into a physical one and clears the outputs when
// no channel is selected. Assumes logical A is encoded 0 and B is encoded 1.
module flexch_chan_map #(
    parameter int LOCAL_W = 34
) (
    input  logic               hit,
    input  logic               swap,
    input  logic               lch_b,
    input  logic               in_ilv,
    input  logic [LOCAL_W-1:0] local_in,
    output logic               phys_chan,
    output logic [LOCAL_W-1:0] local_out,
    output logic               ilv_out
);
    // swap the logical channel and gate everything by hit
    always_comb begin
        phys_chan = hit & (lch_b ^ swap);
        local_out = hit ? local_in : '0;
        ilv_out   = hit & in_ilv;
    end
endmodule

// File: rtl/flexch_addr_map.sv
// Module flexch_addr_map
// Top level of the two-channel address mapper: combinational classification
// and translation, then one output register stage.
// Assumes the configuration inputs are stable while requests are in flight.
module flexch_addr_map
    import flexch_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [SIZE_W-1:0]  cfg_size_a,
    input  logic [SIZE_W-1:0]  cfg_size_b,
    input  logic               cfg_swap,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic               rsp_chan,
    output logic [LOCAL_W-1:0] rsp_local,
    output logic               rsp_ilv,
    output logic               rsp_oor,
    output logic               rsp_cfg_bad
);
    logic               in_range;
    logic               in_ilv;
    logic               cfg_bad;
    logic               lch_b;
    logic [LOCAL_W-1:0] raw_local;
    logic               hit;
    logic               phys_chan;
    logic [LOCAL_W-1:0] gated_local;
    logic               gated_ilv;
    rsp_t               nxt;
    rsp_t               cur;

    flexch_zone_cmp #(
        .SIZE_W     (SIZE_W),
        .UNIT_SHIFT (UNIT_SHIFT)
    ) u_zone (
        .addr     (req_addr),
        .size_a   (cfg_size_a),
        .size_b   (cfg_size_b),
        .in_range (in_range),
        .in_ilv   (in_ilv),
        .cfg_bad  (cfg_bad)
    );

    flexch_local_calc #(
        .SIZE_W     (SIZE_W),
        .UNIT_SHIFT (UNIT_SHIFT),
        .ILV_BIT    (ILV_BIT)
    ) u_calc (
        .addr       (req_addr),
        .size_b     (cfg_size_b),
        .in_ilv     (in_ilv),
        .lch_b      (lch_b),
        .local_addr (raw_local)
    );

    // a channel is selected only for a valid, in-range, well-configured request
    always_comb hit = req_valid & in_range & ~cfg_bad;

    flexch_chan_map #(
        .LOCAL_W (LOCAL_W)
    ) u_map (
        .hit       (hit),
        .swap      (cfg_swap),
        .lch_b     (lch_b),
        .in_ilv    (in_ilv),
        .local_in  (raw_local),
        .phys_chan (phys_chan),
        .local_out (gated_local),
        .ilv_out   (gated_ilv)
    );

    // assemble the next response; flags are only reported for valid requests
    always_comb begin
        nxt.valid      = req_valid;
        nxt.hit        = hit;
        nxt.chan       = phys_chan;
        nxt.local_addr = gated_local;
        nxt.ilv        = gated_ilv;
        nxt.oor        = req_valid & ~in_range;
        nxt.cfg_bad    = req_valid & cfg_bad;
    end

    // output register stage with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= '0;
        else        cur <= nxt;
    end

    // drive the ports from the registered response
    always_comb begin
        rsp_valid   = cur.valid;
        rsp_hit     = cur.hit;
        rsp_chan    = cur.chan;
        rsp_local   = cur.local_addr;
        rsp_ilv     = cur.ilv;
        rsp_oor     = cur.oor;
        rsp_cfg_bad = cur.cfg_bad;
    end
endmodule

// File: rtl/flexch_addr_map_chk.sv
// Module flexch_addr_map_chk
// Port-level properties of the address mapper, bound onto the top module.
module flexch_addr_map_chk
    import flexch_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [SIZE_W-1:0]  cfg_size_a,
    input logic [SIZE_W-1:0]  cfg_size_b,
    input logic               cfg_swap,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_chan,
    input logic [LOCAL_W-1:0] rsp_local,
    input logic               rsp_ilv,
    input logic               rsp_oor,
    input logic               rsp_cfg_bad
);
    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> rsp_valid == $past(req_valid)); // R1

    AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_hit && !rsp_oor && !rsp_cfg_bad); // R1

    AST_CFG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(req_valid) |->
            rsp_cfg_bad == ($past(cfg_size_a) < $past(cfg_size_b))); // R2

    AST_HIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid && !rsp_oor && !rsp_cfg_bad); // R10

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> !rsp_chan && rsp_local == '0 && !rsp_ilv); // R9

    AST_SINGLE_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && rsp_hit && $past(cfg_size_b) == '0 |->
            rsp_chan == $past(cfg_swap) && !rsp_ilv); // R7
endmodule

bind flexch_addr_map flexch_addr_map_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .cfg_size_a  (cfg_size_a),
    .cfg_size_b  (cfg_size_b),
    .cfg_swap    (cfg_swap),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_chan    (rsp_chan),
    .rsp_local   (rsp_local),
    .rsp_ilv     (rsp_ilv),
    .rsp_oor     (rsp_oor),
    .rsp_cfg_bad (rsp_cfg_bad)
);

// File: tb/flexch_addr_map_tb.sv
// Bench for flexch_addr_map: directed corners plus seeded random requests,
// each compared with a behavioural model written from the requirements.
module flexch_addr_map_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [34:0] req_addr;
    logic [7:0]  cfg_size_a;
    logic [7:0]  cfg_size_b;
    logic        cfg_swap;
    logic        rsp_valid, rsp_hit, rsp_chan, rsp_ilv, rsp_oor, rsp_cfg_bad;
    logic [33:0] rsp_local;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;   // 125 MHz

    flexch_addr_map u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .cfg_size_a(cfg_size_a), .cfg_size_b(cfg_size_b), .cfg_swap(cfg_swap),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_chan(rsp_chan),
        .rsp_local(rsp_local), .rsp_ilv(rsp_ilv), .rsp_oor(rsp_oor),
        .rsp_cfg_bad(rsp_cfg_bad)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    // reference model written from R2..R9
    task automatic model(input bit v, input longint a, input int sa, input int sb,
                         input bit sw, output bit hit, output bit ch,
                         output longint loc, output bit ilv, output bit oor,
                         output bit cbad);
        longint unit = 64'd1 << 26;
        bit lb;
        cbad = v && (sa < sb);
        oor  = v && (a >= (sa + sb) * unit);
        hit  = v && !cbad && !oor;
        ch = 0; loc = 0; ilv = 0;
        if (hit) begin
            if (a < 2 * sb * unit) begin
                ilv = 1;
                lb  = a[6];
                loc = ((a >> 7) << 6) | (a & 64'h3f);
            end else begin
                lb  = 0;
                loc = a - sb * unit;
            end
            ch = lb ^ sw;
        end
    endtask

    task automatic send(input bit v, input longint a, input int sa, input int sb,
                        input bit sw);
        bit hit, ch, ilv, oor, cbad;
        longint loc;
        @(negedge clk);
        req_valid  = v;
        req_addr   = a[34:0];
        cfg_size_a = sa[7:0];
        cfg_size_b = sb[7:0];
        cfg_swap   = sw;
        model(v, a, sa, sb, sw, hit, ch, loc, ilv, oor, cbad);
        @(posedge clk);
        #2;
        chk("R1 valid",          rsp_valid,   v);
        chk("R2 cfg_bad",        rsp_cfg_bad, cbad);
        chk("R3 oor",            rsp_oor,     oor);
        chk("R10 hit",           rsp_hit,     hit);
        chk("R4/R6/R7/R8 chan",  rsp_chan,    ch);
        chk("R5/R6/R7/R9 local", rsp_local,   loc);
        chk("R4/R9 ilv",         rsp_ilv,     ilv);
    endtask

    // watchdog: a hung run is a failure
    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        longint unit = 64'd1 << 26;
        int seed_sink;
        seed_sink = $urandom(32'd2024);
        rst_n = 0; req_valid = 1; req_addr = '0;
        cfg_size_a = 8'd4; cfg_size_b = 8'd4; cfg_swap = 0;
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state: all outputs clear even with a request present
        chk("R1 reset valid", rsp_valid, 0);
        chk("R1 reset hit",   rsp_hit,   0);
        chk("R1 reset local", rsp_local, 0);
        @(negedge clk); rst_n = 1; req_valid = 0;

        // R1 idle cycle
        send(0, 64'h40, 4, 4, 0);
        // R4 R5 equal sizes: granule selection and bit squeeze
        send(1, 64'h0,     4, 4, 0);
        send(1, 64'h40,    4, 4, 0);
        send(1, 64'h80,    4, 4, 0);
        send(1, 64'h12345, 4, 4, 0);
        send(1, 8 * unit - 1, 4, 4, 0);
        send(1, 8 * unit,     4, 4, 0);   // R3 first byte past the top
        // R6 unequal sizes: boundary of the linear zone
        send(1, 4 * unit - 64, 8, 2, 0);
        send(1, 4 * unit,      8, 2, 0);
        send(1, 10 * unit - 1, 8, 2, 0);
        send(1, 10 * unit,     8, 2, 0);
        // R7 one channel populated
        send(1, 64'h40,      5, 0, 0);
        send(1, 5 * unit - 1, 5, 0, 1);
        send(1, 5 * unit,     5, 0, 1);
        // R8 swap in both zones
        send(1, 64'h40,   3, 1, 1);
        send(1, 64'h0,    3, 1, 1);
        send(1, 3 * unit, 3, 1, 1);
        // R2 with R3 in the same response, then R2 alone
        send(1, 9 * unit, 2, 5, 0);
        send(1, 64'h40,   2, 5, 0);
        // both channels empty
        send(1, 64'h0, 0, 0, 0);

        // seeded random sweep
        for (int i = 0; i < 600; i++) begin
            int sb = ($urandom % 4 == 0) ? 0 : int'($urandom % 256);
            int sa = sb + int'($urandom % (256 - sb));
            bit sw = $urandom % 2;
            longint span, a;
            if ($urandom % 10 == 0) begin
                int t = sa; sa = sb; sb = t;   // occasionally invert the rule
            end
            span = longint'(sa + sb + 1) * unit;
            a    = {$urandom, $urandom};
            a    = (a & 64'h7_FFFF_FFFF) % span;
            send(($urandom % 8) != 0, a, sa, sb, sw);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule